// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block recovers the bytes of a low-speed USB packet from two line samples (D+ and D-) taken by a clock several times faster than the bit rate. Both lines first pass through a two-flop synchroniser. A phase counter restarts on every line transition, so each bit is sampled near its centre. While idle, the receiver waits for a J-to-K transition. It treats the sync field as complete only when a K is followed by a second K. After sync it NRZI-decodes the line, drops the stuffed bit that follows every run of six decoded ones, and assembles bytes starting with the least significant bit.

Each complete byte leaves through a one-cycle write port, with an address that counts up from zero for each packet. A single-ended zero at a sample point ends the packet. The block then raises a done pulse and shows the number of complete bytes. A packet with more bytes than the buffer holds is abandoned with an overflow pulse. When the line shows a single-ended zero while hunting and no sync edge follows within a timeout, the block raises a sync-error pulse. This event serves as a frame-start marker.

Top module: `lsUsbRx`

## Requirements
- R1: The line state is read from the synchronised pair {D+, D-}: 2'b01 is J (idle), 2'b10 is K, and 2'b00 is single-ended zero (SE0).
- R2: A packet starts only after a J-to-K transition whose K is followed, one bit time later, by another K. If a J follows that first K instead, the receiver goes back to hunting, and the stray K/J pattern produces no write, done, overflow or sync-error pulse.
- R3: A data bit is decoded as 1 when its line level equals the previous sampled level, and as 0 when the level changed. The reference for the first data bit is the last K of the sync field.
- R4: After six consecutive decoded 1s, the next line bit is discarded and does not appear in the data.
- R5: Each byte is assembled with its first received bit in bit 0. It is written with `wrEn` high for one cycle, and `wrAddr` runs 0, 1, 2 and so on within a packet.
- R6: An SE0 at a data sample point ends the packet. `pktDone` pulses for one cycle, and `pktLen` then equals the number of complete bytes. Bits of an unfinished byte are dropped and never written.
- R7: If a byte completes when `BUF_BYTES` bytes have already been written, that byte is not written. `overflow` pulses for one cycle, no `pktDone` follows for that packet, and exactly `BUF_BYTES` bytes is still a normal packet.
- R8: An SE0 seen while hunting arms a timer. If no J-to-K transition follows within `SYNC_TIMEOUT` cycles, `syncErr` pulses once. The SE0 that ends a packet does not arm this timer.
- R9: While and after reset, `wrEn`, `pktDone`, `overflow` and `syncErr` are low and `pktLen` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, `SPB` cycles per bit |
| rstN | input | 1 | Active-low synchronous reset |
| dpIn | input | 1 | D+ line, asynchronous |
| dmIn | input | 1 | D- line, asynchronous |
| wrEn | output | 1 | Byte write strobe |
| wrAddr | output | ADDR_W | Byte index within the packet |
| wrData | output | 8 | Received byte |
| pktDone | output | 1 | One-cycle end-of-packet pulse |
| pktLen | output | LEN_W | Complete bytes in the packet |
| overflow | output | 1 | One-cycle pulse when the buffer limit is exceeded |
| syncErr | output | 1 | One-cycle pulse when no sync edge follows the wake-up within the timeout |

## Verification
The bench builds the block with 8 samples per bit, a 4-byte buffer and a 40-cycle sync timeout. The small buffer brings the overflow boundary within reach in a few packets: four bytes complete normally and five overflow. The short timeout lets a lone SE0 keep-alive produce its sync-error pulse within a dozen bit times. The same setting also shows that the SE0 ending a packet raises no sync error. All-ones bytes force stuffing across byte boundaries. A trailing partial byte and an empty packet exercise the length count.

// File: rtl/lsUsbRxPkg.sv
package lsUsbRxPkg;

  typedef enum logic [1:0] {
    LVL_SE0 = 2'b00,
    LVL_J   = 2'b01,
    LVL_K   = 2'b10,
    LVL_ILL = 2'b11
  } lineLvl_e;

  typedef struct packed {
    logic startPkt;
    logic shiftEn;
    logic bitVal;
    logic commit;
  } rxStrobe_t;

endpackage

// File: rtl/lsUsbRxPath.sv
module lsUsbRxPath
  import lsUsbRxPkg::*;
#(
  parameter int SPB       = 8,
  parameter int BUF_BYTES = 8,
  localparam int ADDR_W   = (BUF_BYTES > 2) ? $clog2(BUF_BYTES) : 1,
  localparam int LEN_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dpIn,
  input  logic              dmIn,
  input  rxStrobe_t         strb,
  output lineLvl_e          lvl,
  output lineLvl_e          lvlPrev,
  output logic              sampleTick,
  output logic [2:0]        bitIdx,
  output logic [LEN_W-1:0]  byteCnt,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData
);

  localparam int CNT_W = $clog2(SPB);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(SPB / 2);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SPB - 1);

  logic [1:0] meta, syncd, prevRaw;
  logic [CNT_W-1:0] phase;
  logic [7:0] shReg;

  // two-flop synchroniser, then one more stage for transition detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      meta    <= 2'b01;
      syncd   <= 2'b01;
      prevRaw <= 2'b01;
    end else begin
      meta    <= {dpIn, dmIn};
      syncd   <= meta;
      prevRaw <= syncd;
    end
  end

  assign lvl     = lineLvl_e'(syncd);
  assign lvlPrev = lineLvl_e'(prevRaw);

  // phase counter re-centred on every transition
  always_ff @(posedge clk) begin
    if (!rstN)                phase <= '0;
    else if (lvl != lvlPrev)  phase <= '0;
    else if (phase == LAST)   phase <= '0;
    else                      phase <= phase + 1'b1;
  end

  assign sampleTick = (phase == HALF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg   <= '0;
      bitIdx  <= '0;
      byteCnt <= '0;
      wrEn    <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else begin
      wrEn <= 1'b0;
      if (strb.startPkt) begin
        bitIdx  <= '0;
        byteCnt <= '0;
      end else if (strb.shiftEn) begin
        shReg  <= {strb.bitVal, shReg[7:1]};
        bitIdx <= bitIdx + 1'b1;
        if (strb.commit) begin
          wrEn    <= 1'b1;
          wrAddr  <= ADDR_W'(byteCnt);
          wrData  <= {strb.bitVal, shReg[7:1]};
          byteCnt <= byteCnt + 1'b1;
        end
      end
    end
  end

  // R7: the controller never commits a byte once the buffer is full
  a_r7_commit_room: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (byteCnt < LEN_W'(BUF_BYTES)));

  // R5: a write carries the index just before the updated count
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (LEN_W'(wrAddr) == byteCnt - 1'b1));

endmodule

// File: rtl/lsUsbRxCtrl.sv
module lsUsbRxCtrl
  import lsUsbRxPkg::*;
#(
  parameter int BUF_BYTES    = 8,
  parameter int SYNC_TIMEOUT = 1000,
  localparam int LEN_W       = $clog2(BUF_BYTES + 1),
  localparam int TMR_W       = $clog2(SYNC_TIMEOUT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  lineLvl_e         lvl,
  input  lineLvl_e         lvlPrev,
  input  logic             sampleTick,
  input  logic [2:0]       bitIdx,
  input  logic [LEN_W-1:0] byteCnt,
  output rxStrobe_t        strb,
  output logic             pktDone,
  output logic             overflow,
  output logic             syncErr
);

  typedef enum logic [2:0] {
    ST_HUNT, ST_CHK, ST_DATA, ST_DROP, ST_EOPW
  } rxState_e;

  rxState_e   state;
  lineLvl_e   lastLvl;
  logic [2:0] onesCnt;
  logic       seenFirst;
  logic       armed;
  logic [TMR_W-1:0] tmr;

  logic dataTick, dataBit, stuffNow, bufFull, lastBit;

  assign dataTick = (state == ST_DATA) && sampleTick && (lvl != LVL_SE0);
  assign dataBit  = (lvl == lastLvl);
  assign stuffNow = (onesCnt == 3'd6);
  assign lastBit  = (bitIdx == 3'd7);
  assign bufFull  = (byteCnt == LEN_W'(BUF_BYTES));

  always_comb begin
    strb = '0;
    strb.startPkt = (state == ST_CHK) && sampleTick && seenFirst && (lvl == LVL_K);
    if (dataTick && !stuffNow && !(lastBit && bufFull)) begin
      strb.shiftEn = 1'b1;
      strb.bitVal  = dataBit;
      strb.commit  = lastBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_HUNT;
      lastLvl   <= LVL_K;
      onesCnt   <= '0;
      seenFirst <= 1'b0;
      armed     <= 1'b0;
      tmr       <= '0;
      pktDone   <= 1'b0;
      overflow  <= 1'b0;
      syncErr   <= 1'b0;
    end else begin
      pktDone  <= 1'b0;
      overflow <= 1'b0;
      syncErr  <= 1'b0;
      unique case (state)
        ST_HUNT: begin
          if (lvl == LVL_SE0) begin
            armed <= 1'b1;
            tmr   <= '0;
          end else if (lvlPrev == LVL_J && lvl == LVL_K) begin
            state     <= ST_CHK;
            seenFirst <= 1'b0;
            armed     <= 1'b0;
          end else if (armed) begin
            if (tmr == TMR_W'(SYNC_TIMEOUT - 1)) begin
              syncErr <= 1'b1;
              armed   <= 1'b0;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
        end
        ST_CHK: begin
          if (sampleTick) begin
            if (lvl == LVL_SE0) begin
              state <= ST_HUNT;
            end else if (!seenFirst) begin
              seenFirst <= 1'b1;
            end else if (lvl == LVL_K) begin
              state   <= ST_DATA;
              lastLvl <= LVL_K;
              onesCnt <= '0;
            end else begin
              state <= ST_HUNT;
            end
          end
        end
        ST_DATA: begin
          if (sampleTick && lvl == LVL_SE0) begin
            pktDone <= 1'b1;
            state   <= ST_EOPW;
          end else if (dataTick) begin
            lastLvl <= lvl;
            if (stuffNow) begin
              onesCnt <= '0;
            end else if (lastBit && bufFull) begin
              overflow <= 1'b1;
              state    <= ST_DROP;
            end else begin
              onesCnt <= dataBit ? onesCnt + 1'b1 : 3'd0;
            end
          end
        end
        ST_DROP: if (lvl == LVL_SE0) state <= ST_EOPW;
        ST_EOPW: if (lvl == LVL_J) state <= ST_HUNT;
        default: state <= ST_HUNT;
      endcase
    end
  end

  // R6: done is a single-cycle pulse with an in-range length
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |=> !pktDone);
  a_r6_len_bound: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |-> (byteCnt <= LEN_W'(BUF_BYTES)));
  // R7: overflow never coincides with another status pulse
  a_r7_ovf_alone: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (!pktDone && !syncErr));
  // R8: sync error is a single-cycle pulse
  a_r8_serr_pulse: assert property (@(posedge clk) disable iff (!rstN)
    syncErr |=> !syncErr);
  // R3: data decoding starts from a K reference
  a_r3_ref_k: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_CHK && state == ST_DATA) |-> (lastLvl == LVL_K));

endmodule

// File: rtl/lsUsbRx.sv
module lsUsbRx
  import lsUsbRxPkg::*;
#(
  parameter int SPB          = 8,
  parameter int BUF_BYTES    = 8,
  parameter int SYNC_TIMEOUT = 1000,
  localparam int ADDR_W      = (BUF_BYTES > 2) ? $clog2(BUF_BYTES) : 1,
  localparam int LEN_W       = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dpIn,
  input  logic              dmIn,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              pktDone,
  output logic [LEN_W-1:0]  pktLen,
  output logic              overflow,
  output logic              syncErr
);

  rxStrobe_t        strb;
  lineLvl_e         lvl, lvlPrev;
  logic             sampleTick;
  logic [2:0]       bitIdx;
  logic [LEN_W-1:0] byteCnt;

  lsUsbRxPath #(.SPB(SPB), .BUF_BYTES(BUF_BYTES)) u_path (
    .clk(clk), .rstN(rstN), .dpIn(dpIn), .dmIn(dmIn), .strb(strb),
    .lvl(lvl), .lvlPrev(lvlPrev), .sampleTick(sampleTick),
    .bitIdx(bitIdx), .byteCnt(byteCnt),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  lsUsbRxCtrl #(.BUF_BYTES(BUF_BYTES), .SYNC_TIMEOUT(SYNC_TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .lvl(lvl), .lvlPrev(lvlPrev),
    .sampleTick(sampleTick), .bitIdx(bitIdx), .byteCnt(byteCnt),
    .strb(strb), .pktDone(pktDone), .overflow(overflow), .syncErr(syncErr)
  );

  assign pktLen = byteCnt;

endmodule

// File: tb/lsUsbRx_tb.sv
module lsUsbRx_tb;

  localparam int SPB = 8;
  localparam int BUF = 4;
  localparam int TOUT = 40;
  localparam int AW = 2;
  localparam int LW = 3;

  logic clk = 1'b0, rstN = 1'b0, dpIn = 1'b0, dmIn = 1'b1;
  logic wrEn, pktDone, overflow, syncErr;
  logic [AW-1:0] wrAddr;
  logic [7:0] wrData;
  logic [LW-1:0] pktLen;

  always #2.5 clk = ~clk;

  lsUsbRx #(.SPB(SPB), .BUF_BYTES(BUF), .SYNC_TIMEOUT(TOUT)) u_dut (
    .clk(clk), .rstN(rstN), .dpIn(dpIn), .dmIn(dmIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .pktDone(pktDone),
    .pktLen(pktLen), .overflow(overflow), .syncErr(syncErr)
  );

  typedef enum int {EV_WR, EV_DONE, EV_OVF, EV_SERR} evKind_e;
  typedef struct { evKind_e kind; int a; int b; string req; } expEv_t;

  expEv_t expQ[$];
  logic [7:0] txq[$];
  int checks = 0, failures = 0;
  bit finished = 0;
  logic curDp;
  int ones;

  function automatic string kindName(evKind_e k);
    case (k)
      EV_WR: return "write";
      EV_DONE: return "done";
      EV_OVF: return "overflow";
      default: return "syncErr";
    endcase
  endfunction

  // monitor: pops expectations as the design produces results
  task automatic seeEvent(evKind_e k, int a, int b);
    expEv_t e;
    checks++;
    if (expQ.size() == 0) begin
      failures++;
      $display("FAIL R2 unexpected %s a=%0d b=%0d expected nothing", kindName(k), a, b);
      return;
    end
    e = expQ.pop_front();
    if (e.kind != k || e.a != a || e.b != b) begin
      failures++;
      $display("FAIL %s got %s a=%0d b=0x%0h expected %s a=%0d b=0x%0h",
               e.req, kindName(k), a, b, kindName(e.kind), e.a, e.b);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (wrEn)     seeEvent(EV_WR, int'(wrAddr), int'(wrData));
      if (pktDone)  seeEvent(EV_DONE, int'(pktLen), 0);
      if (overflow) seeEvent(EV_OVF, 0, 0);
      if (syncErr)  seeEvent(EV_SERR, 0, 0);
    end
  end

  function automatic void pushExp(evKind_e k, int a, int b, string req);
    expEv_t e;
    e.kind = k; e.a = a; e.b = b; e.req = req;
    expQ.push_back(e);
  endfunction

  // R1: J = {0,1}, K = {1,0}, SE0 = {0,0}
  task automatic lineBits(logic dp, logic dm, int n);
    dpIn = dp; dmIn = dm;
    repeat (SPB * n) @(negedge clk);
  endtask

  task automatic sendLevel(logic dp);
    lineBits(dp, ~dp, 1);
    curDp = dp;
  endtask

  // NRZI encode with stuffing: 1 keeps the level, 0 toggles
  task automatic sendData(logic b);
    if (b) begin
      sendLevel(curDp);
      ones++;
      if (ones == 6) begin
        sendLevel(~curDp);
        ones = 0;
      end
    end else begin
      sendLevel(~curDp);
      ones = 0;
    end
  endtask

  task automatic sendSync();
    lineBits(1'b0, 1'b1, 3);
    sendLevel(1'b1); sendLevel(1'b0); sendLevel(1'b1); sendLevel(1'b0);
    sendLevel(1'b1); sendLevel(1'b0); sendLevel(1'b1); sendLevel(1'b1);
    ones = 0;
  endtask

  // driver: sends txq plus extra trailing bits and queues the expectations
  task automatic sendPkt(int extra, logic [7:0] extraVal, string req);
    int n = txq.size();
    sendSync();
    for (int i = 0; i < n; i++) begin
      if (i < BUF) pushExp(EV_WR, i, int'(txq[i]), req);
      else if (i == BUF) pushExp(EV_OVF, 0, 0, "R7");
      for (int k = 0; k < 8; k++) sendData(txq[i][k]);
    end
    for (int k = 0; k < extra; k++) sendData(extraVal[k]);
    if (n <= BUF) pushExp(EV_DONE, n, 0, (extra > 0) ? "R6" : req);
    lineBits(1'b0, 1'b0, 2);
    lineBits(1'b0, 1'b1, 8);
    txq.delete();
  endtask

  initial begin
    repeat (1000 * SPB) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired with %0d expectations pending", expQ.size());
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    curDp = 1'b0;
    ones = 0;
    repeat (5) @(negedge clk);
    checks++;
    if (wrEn || pktDone || overflow || syncErr || pktLen != 0) begin
      failures++;
      $display("FAIL R9 outputs during reset wr=%b done=%b ovf=%b serr=%b len=%0d expected all zero",
               wrEn, pktDone, overflow, syncErr, pktLen);
    end
    rstN = 1'b1;
    lineBits(1'b0, 1'b1, 4);
    checks++;
    if (wrEn || pktDone || overflow || syncErr || pktLen != 0) begin
      failures++;
      $display("FAIL R9 outputs after reset wr=%b done=%b ovf=%b serr=%b len=%0d expected all zero",
               wrEn, pktDone, overflow, syncErr, pktLen);
    end

    // R3 R5: single mixed byte
    txq = '{8'hA5};
    sendPkt(0, 8'h00, "R3");
    // R4: long runs of ones, stuffing across byte boundaries
    txq = '{8'hFF, 8'hFF, 8'h7E};
    sendPkt(0, 8'h00, "R4");
    // R5: several bytes with varied patterns
    txq = '{8'h01, 8'h80, 8'h3C, 8'hC3};
    sendPkt(0, 8'h00, "R5");
    // R6: partial trailing byte dropped
    txq = '{8'h12, 8'h9A};
    sendPkt(5, 8'h1F, "R6");
    // R6: empty packet
    sendPkt(0, 8'h00, "R6");
    // R2: stray K then J must not start a packet
    lineBits(1'b0, 1'b1, 3);
    lineBits(1'b1, 1'b0, 1);
    lineBits(1'b0, 1'b1, 6);
    txq = '{8'h5A};
    sendPkt(0, 8'h00, "R2");
    // R7: one byte too many
    txq = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    sendPkt(0, 8'h00, "R7");
    // R7: exactly full is a normal packet
    txq = '{8'hF0, 8'h0F, 8'hAA, 8'h55};
    sendPkt(0, 8'h00, "R7");
    // R8: lone SE0 without sync edge
    pushExp(EV_SERR, 0, 0, "R8");
    lineBits(1'b0, 1'b0, 2);
    lineBits(1'b0, 1'b1, 12);
    // R8: SE0 followed quickly by a packet raises no sync error
    lineBits(1'b0, 1'b0, 2);
    txq = '{8'h69};
    sendPkt(0, 8'h00, "R8");

    lineBits(1'b0, 1'b1, 10);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL %s %0d expected events never seen, expected 0 pending",
               expQ[0].req, expQ.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule